// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write side of a parallel NOR flash command port and turns the multi-write unlock sequences into single commands. Each bus write reaches it as a one-cycle strobe with the write address, the data word and a byte/word mode input. The block recognises the unlock pairs, tracks where the host is inside a sequence, and issues a one-cycle registered pulse for each command it completes. The program address and data are latched alongside the pulse.

A registered two-bit mode output tells the surrounding flash controller how reads are served: plain array, identification data, unlock bypass (the array is read normally), or the query table. A busy input from the program/erase engine freezes the decoder. The one exception is a suspend request, which is honoured only while a block erase is running.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, mode is 0 (read), every command pulse is low, and the latched address and data are zero.
- R2: The two unlock writes are data AAh then data 55h. In word mode (byte_mode=0) they go to addresses 555h then 2AAh, compared on address bits 10:0. In byte mode (byte_mode=1) they go to AAAh then 555h, compared on address bits 11:0. Higher address bits and data bits 15:8 never affect matching.
- R3: In read mode, two unlock writes followed by a third write to the first unlock address act as follows. Data 90h pulses cmd_autosel and sets mode 1. Data 20h pulses cmd_bypass_enter and sets mode 2. Each pulse appears in the cycle after the third write.
- R4: Two unlock writes, then A0h to the first unlock address, then any fourth write: this pulses cmd_prog, and cmd_addr/cmd_data show that fourth write's full address and data.
- R5: In read, auto select or query mode, a write with data F0h pulses cmd_reset and sets mode 0. This applies whether it comes alone or after one or more unlock writes. The single exception is the data write of a program sequence.
- R6: A write that does not fit the sequence in progress discards it, produces no pulse and leaves mode unchanged. That write does not begin a new sequence.
- R7: In mode 2, data A0h followed by any write pulses cmd_bypass_prog and latches that write's address and data. Data 90h followed by 00h pulses cmd_bypass_exit and sets mode 0. F0h and any other writes leave mode 2 in place with no pulse.
- R8: In mode 1, writes other than F0h and the query write produce no pulse and leave mode 1.
- R9: Data 98h written to address 55h (word mode) or AAh (byte mode) from mode 0 or 1 sets mode 3 with no pulse. F0h returns to mode 0.
- R10: From read mode, the six-write erase sequence is: unlock, 80h to the first unlock address, unlock again, then a final write. If the final write is 10h to the first unlock address, it pulses cmd_chip_erase. If it is 30h to any address, it pulses cmd_block_erase and latches that address into cmd_addr.
- R11: While busy is high, writes produce no pulse and change no state. The exception is data B0h, which pulses cmd_suspend if the most recent non-busy write issued a block erase.
- R12: At most one command pulse is high in any cycle, and a pulse is high only in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe per bus write |
| wr_addr | input | ADDR_W | Write address (byte address in byte mode) |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command byte |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| busy | input | 1 | Program/erase engine running |
| cmd_reset | output | 1 | Read/reset command pulse |
| cmd_autosel | output | 1 | Auto select entry pulse |
| cmd_prog | output | 1 | Program command pulse |
| cmd_bypass_enter | output | 1 | Unlock bypass entry pulse |
| cmd_bypass_prog | output | 1 | Bypass program pulse |
| cmd_bypass_exit | output | 1 | Bypass exit pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_block_erase | output | 1 | Block erase pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_addr | output | ADDR_W | Latched program or erase-block address |
| cmd_data | output | DATA_W | Latched program data |
| mode | output | 2 | 0 read, 1 auto select, 2 unlock bypass, 3 query |

## Verification
The hardest situation to reach from the ports is the suspend window. It needs a complete six-write block erase, then busy raised, then a B0h write. A second case must show that one non-busy write in between disarms it. The stimulus builds exactly that chain, then repeats the B0h after a program and after an intervening idle write, so both the armed and disarmed cases are seen. Byte-mode aliasing is also driven on purpose: word-mode unlock addresses are written in byte mode, and unlock writes carry stray high address and data bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_BYPASS = 2'd2,
    MODE_QUERY  = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_ER3, ST_ER4, ST_ER5, ST_BPGM, ST_BRST
  } step_e;

  typedef enum logic [3:0] {
    CMD_NONE        = 4'd0,
    CMD_RESET       = 4'd1,
    CMD_AUTOSEL     = 4'd2,
    CMD_PROG        = 4'd3,
    CMD_BYP_ENTER   = 4'd4,
    CMD_BYP_PROG    = 4'd5,
    CMD_BYP_EXIT    = 4'd6,
    CMD_CHIP_ERASE  = 4'd7,
    CMD_BLOCK_ERASE = 4'd8,
    CMD_SUSPEND     = 4'd9
  } cmd_e;

  localparam int NUM_PULSE = 9;
  localparam int KEY_W     = 12;

  localparam logic [7:0] D_UNL1   = 8'hAA;
  localparam logic [7:0] D_UNL2   = 8'h55;
  localparam logic [7:0] D_AUTO   = 8'h90;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_BYPASS = 8'h20;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_BLOCK  = 8'h30;
  localparam logic [7:0] D_RESET  = 8'hF0;
  localparam logic [7:0] D_QUERY  = 8'h98;
  localparam logic [7:0] D_SUSP   = 8'hB0;
  localparam logic [7:0] D_BEXIT  = 8'h00;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match
  import flash_cmd_pkg::*;
#(
  parameter logic [KEY_W-1:0] W_UNL1  = 12'h555,
  parameter logic [KEY_W-1:0] W_UNL2  = 12'h2AA,
  parameter logic [KEY_W-1:0] W_QUERY = 12'h055
) (
  input  logic [KEY_W-1:0] addr_lo,
  input  logic             byte_mode,
  output logic             hit_unl1,
  output logic             hit_unl2,
  output logic             hit_query
);
  // Byte mode shifts every word address up by one (the extra low bit).
  localparam logic [KEY_W-1:0] B_UNL1  = {W_UNL1[KEY_W-2:0], 1'b0};
  localparam logic [KEY_W-1:0] B_UNL2  = {W_UNL2[KEY_W-2:0], 1'b0} | 12'h001;
  localparam logic [KEY_W-1:0] B_QUERY = {W_QUERY[KEY_W-2:0], 1'b0};

  logic [KEY_W-1:0] key;

  always_comb begin
    key       = byte_mode ? addr_lo : {1'b0, addr_lo[KEY_W-2:0]};
    hit_unl1  = key == (byte_mode ? B_UNL1  : W_UNL1);
    hit_unl2  = key == (byte_mode ? B_UNL2  : W_UNL2);
    hit_query = key == (byte_mode ? B_QUERY : W_QUERY);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic       busy,
  input  logic [7:0] dat,
  input  logic       hit_unl1,
  input  logic       hit_unl2,
  input  logic       hit_query,
  output cmd_e       code,
  output mode_e      mode_q
);
  step_e step_q, step_n;
  mode_e mode_n;
  logic  blk_q, blk_n;

  always_comb begin
    step_n = step_q;
    mode_n = mode_q;
    blk_n  = blk_q;
    code   = CMD_NONE;
    if (wr_stb) begin
      if (busy) begin
        if (dat == D_SUSP && blk_q) code = CMD_SUSPEND;
      end else begin
        blk_n = 1'b0;
        if (mode_q == MODE_BYPASS) begin
          step_n = ST_IDLE;
          case (step_q)
            ST_BPGM: code = CMD_BYP_PROG;
            ST_BRST: if (dat == D_BEXIT) begin
              code   = CMD_BYP_EXIT;
              mode_n = MODE_READ;
            end
            default: if (dat == D_PROG) step_n = ST_BPGM;
                     else if (dat == D_AUTO) step_n = ST_BRST;
          endcase
        end else if (step_q == ST_PGM) begin
          code   = CMD_PROG;
          step_n = ST_IDLE;
        end else if (dat == D_RESET) begin
          code   = CMD_RESET;
          mode_n = MODE_READ;
          step_n = ST_IDLE;
        end else begin
          step_n = ST_IDLE;
          case (step_q)
            ST_IDLE: begin
              if (hit_unl1 && dat == D_UNL1) step_n = ST_UNL1;
              else if (hit_query && dat == D_QUERY && mode_q != MODE_QUERY) mode_n = MODE_QUERY;
            end
            ST_UNL1: if (hit_unl2 && dat == D_UNL2) step_n = ST_UNL2;
            ST_UNL2: if (hit_unl1 && mode_q == MODE_READ) begin
              case (dat)
                D_AUTO:   begin code = CMD_AUTOSEL;   mode_n = MODE_AUTO;   end
                D_BYPASS: begin code = CMD_BYP_ENTER; mode_n = MODE_BYPASS; end
                D_PROG:   step_n = ST_PGM;
                D_ERASE:  step_n = ST_ER3;
                default:  step_n = ST_IDLE;
              endcase
            end
            ST_ER3: if (hit_unl1 && dat == D_UNL1) step_n = ST_ER4;
            ST_ER4: if (hit_unl2 && dat == D_UNL2) step_n = ST_ER5;
            ST_ER5: begin
              if (hit_unl1 && dat == D_CHIP) code = CMD_CHIP_ERASE;
              else if (dat == D_BLOCK) begin
                code  = CMD_BLOCK_ERASE;
                blk_n = 1'b1;
              end
            end
            default: step_n = ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      mode_q <= MODE_READ;
      blk_q  <= 1'b0;
    end else begin
      step_q <= step_n;
      mode_q <= mode_n;
      blk_q  <= blk_n;
    end
  end

  // R8: auto select holds against every write except reset and query
  a_r8_auto_locked: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_AUTO && wr_stb && !busy && dat != D_RESET && dat != D_QUERY)
      |=> (mode_q == MODE_AUTO));

  // R9: query mode is left only through a reset write
  a_r9_query_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_QUERY && !(wr_stb && !busy && dat == D_RESET)) |=> (mode_q == MODE_QUERY));
endmodule

// File: rtl/fcd_cmd_out.sv
module fcd_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NP     = NUM_PULSE
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NP-1:0]     pulse,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  for (genvar i = 0; i < NP; i++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= (code == cmd_e'(i + 1));
    end
  end

  logic take_addr, take_data;
  assign take_data = (code == CMD_PROG) || (code == CMD_BYP_PROG);
  assign take_addr = take_data || (code == CMD_BLOCK_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (take_addr) addr_q <= addr;
      if (take_data) data_q <= data;
    end
  end

  // R12: no two command pulses together
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(pulse));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_mode,
  input  logic              busy,
  output logic              cmd_reset,
  output logic              cmd_autosel,
  output logic              cmd_prog,
  output logic              cmd_bypass_enter,
  output logic              cmd_bypass_prog,
  output logic              cmd_bypass_exit,
  output logic              cmd_chip_erase,
  output logic              cmd_block_erase,
  output logic              cmd_suspend,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [1:0]        mode
);
  logic              hit_unl1, hit_unl2, hit_query;
  cmd_e              code;
  mode_e             mode_q;
  logic [NUM_PULSE-1:0] pulse;

  fcd_addr_match u_match (
    .addr_lo   (wr_addr[KEY_W-1:0]),
    .byte_mode (byte_mode),
    .hit_unl1  (hit_unl1),
    .hit_unl2  (hit_unl2),
    .hit_query (hit_query)
  );

  fcd_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .dat       (wr_data[7:0]),
    .hit_unl1  (hit_unl1),
    .hit_unl2  (hit_unl2),
    .hit_query (hit_query),
    .code      (code),
    .mode_q    (mode_q)
  );

  fcd_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NP(NUM_PULSE)) u_out (
    .clk    (clk),
    .rst    (rst),
    .code   (code),
    .addr   (wr_addr),
    .data   (wr_data),
    .pulse  (pulse),
    .addr_q (cmd_addr),
    .data_q (cmd_data)
  );

  assign {cmd_suspend, cmd_block_erase, cmd_chip_erase, cmd_bypass_exit, cmd_bypass_prog,
          cmd_bypass_enter, cmd_prog, cmd_autosel, cmd_reset} = pulse;
  assign mode = mode_q;

  // R12: a pulse always follows a write strobe
  a_r12_after_write: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |-> $past(wr_stb));

  // R11: a busy non-suspend write leaves everything untouched
  a_r11_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && busy && wr_data[7:0] != D_SUSP) |=> (pulse == '0 && $stable(mode)));

  // R4 and R7: the latched pair is the write that completed the program
  a_r4_prog_latch: assert property (@(posedge clk) disable iff (rst)
    (cmd_prog || cmd_bypass_prog) |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

  // R7: a reset byte does not leave bypass mode
  a_r7_bypass_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && wr_stb && !busy && wr_data[7:0] == D_RESET) |=> (mode == 2'd2));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int P_RST = 0, P_AUT = 1, P_PRG = 2, P_BEN = 3, P_BPG = 4,
                 P_BEX = 5, P_CHP = 6, P_BLK = 7, P_SUS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic byte_mode = 1'b0;
  logic busy = 1'b0;
  logic c_rst, c_aut, c_prg, c_ben, c_bpg, c_bex, c_chp, c_blk, c_sus;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [1:0] mode;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_mode(byte_mode), .busy(busy),
    .cmd_reset(c_rst), .cmd_autosel(c_aut), .cmd_prog(c_prg), .cmd_bypass_enter(c_ben),
    .cmd_bypass_prog(c_bpg), .cmd_bypass_exit(c_bex), .cmd_chip_erase(c_chp),
    .cmd_block_erase(c_blk), .cmd_suspend(c_sus),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .mode(mode));

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  int qd[$];
  int m_mode = 0;
  bit m_blk = 0;
  logic [8:0] exp_p = '0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ma, db, u1, u2, uq;
    bit keep;
    db = int'(d[7:0]);
    ma = byte_mode ? int'(a[11:0]) : int'(a[10:0]);
    u1 = byte_mode ? 'hAAA : 'h555;
    u2 = byte_mode ? 'h555 : 'h2AA;
    uq = byte_mode ? 'hAA  : 'h55;
    if (busy) begin
      if (db == 'hB0 && m_blk) exp_p[P_SUS] = 1'b1;
      return;
    end
    m_blk = 0;
    if (m_mode == 2) begin
      if (qd.size() == 0) begin
        if (db == 'hA0 || db == 'h90) qd.push_back(db);
      end else begin
        if (qd[0] == 'hA0) begin exp_p[P_BPG] = 1'b1; exp_addr = a; exp_data = d; end
        else if (db == 0) begin exp_p[P_BEX] = 1'b1; m_mode = 0; end
        qd.delete();
      end
      return;
    end
    if (qd.size() == 3 && qd[2] == 'hA0) begin
      exp_p[P_PRG] = 1'b1; exp_addr = a; exp_data = d; qd.delete(); return;
    end
    if (db == 'hF0) begin exp_p[P_RST] = 1'b1; m_mode = 0; qd.delete(); return; end
    qd.push_back(db);
    keep = 0;
    case (qd.size())
      1: if (ma == u1 && db == 'hAA) keep = 1;
         else if (ma == uq && db == 'h98 && m_mode != 3) m_mode = 3;
      2: keep = (ma == u2 && db == 'h55);
      3: if (ma == u1 && m_mode == 0) begin
           if (db == 'h90) begin exp_p[P_AUT] = 1'b1; m_mode = 1; end
           else if (db == 'h20) begin exp_p[P_BEN] = 1'b1; m_mode = 2; end
           else if (db == 'hA0 || db == 'h80) keep = 1;
         end
      4: keep = (ma == u1 && db == 'hAA);
      5: keep = (ma == u2 && db == 'h55);
      6: if (ma == u1 && db == 'h10) exp_p[P_CHP] = 1'b1;
         else if (db == 'h30) begin exp_p[P_BLK] = 1'b1; exp_addr = a; m_blk = 1; end
      default: keep = 0;
    endcase
    if (!keep) qd.delete();
  endtask

  always @(posedge clk) begin
    exp_p = '0;
    if (rst) begin
      qd.delete(); m_mode = 0; m_blk = 0; exp_addr = '0; exp_data = '0;
    end else if (wr_stb) begin
      model_write(wr_addr, wr_data);
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      logic [8:0] got;
      got = {c_sus, c_blk, c_chp, c_bex, c_bpg, c_ben, c_prg, c_aut, c_rst};
      chk(got == exp_p, "pulses", got, exp_p);
      chk(mode == 2'(m_mode), "mode", mode, m_mode);
      chk(cmd_addr == exp_addr, "cmd_addr", cmd_addr, exp_addr);
      chk(cmd_data == exp_data, "cmd_data", cmd_data, exp_data);
      chk($countones(got) <= 1, "R12 pulse count", $countones(got), 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock_w();
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055);
  endtask

  task automatic unlock_b();
    wr(20'h00AAA, 16'h00AA); wr(20'h00555, 16'h0055);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    cur_req = "R1"; idle(3);

    cur_req = "R3"; unlock_w(); wr(20'h00555, 16'h0090); idle(2);
    cur_req = "R8"; unlock_w(); wr(20'h00555, 16'h00A0); wr(20'h01234, 16'h5678);
    unlock_w(); wr(20'h00555, 16'h0020); wr(20'h00555, 16'h0080); idle(2);
    cur_req = "R9"; wr(20'h00055, 16'h0098); unlock_w(); wr(20'h00555, 16'h0090); idle(1);
    cur_req = "R5"; wr(20'h3ABCD, 16'h00F0); idle(2);

    cur_req = "R2"; unlock_w(); wr(20'h7F555, 16'hFFA0); wr(20'h12345, 16'hBEEF); idle(2);
    cur_req = "R4"; wr(20'hFD555, 16'h12AA); wr(20'hAB2AA, 16'h3455);
    wr(20'h00555, 16'h00A0); wr(20'h00000, 16'h00F0); idle(2);
    cur_req = "R6"; wr(20'h00555, 16'h00AA); wr(20'h002AB, 16'h0055);
    wr(20'h00555, 16'h0090); idle(1);
    unlock_w(); wr(20'h00556, 16'h0090); wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055);
    idle(2);
    cur_req = "R5"; unlock_w(); wr(20'h00000, 16'h00F0);
    wr(20'h00555, 16'h00AA); wr(20'h00001, 16'h00F0); idle(2);

    cur_req = "R2"; byte_mode = 1'b1;
    unlock_w(); wr(20'h00555, 16'h0090); idle(1);
    unlock_b(); wr(20'h00AAA, 16'h00A0); wr(20'h54321, 16'hCAFE); idle(2);
    cur_req = "R9"; wr(20'h000AA, 16'h0098); wr(20'h00AAA, 16'h00AA); wr(20'h00000, 16'h00F0);
    wr(20'h00055, 16'h0098); idle(2);
    byte_mode = 1'b0;

    cur_req = "R7"; unlock_w(); wr(20'h00555, 16'h0020);
    wr(20'h00000, 16'h00A0); wr(20'h22222, 16'h1111);
    wr(20'h00007, 16'h00A0); wr(20'h33333, 16'h00F0);
    wr(20'h00000, 16'h00F0); unlock_w(); wr(20'h00555, 16'h0090);
    wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0012);
    wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000); idle(2);

    cur_req = "R10"; unlock_w(); wr(20'h00555, 16'h0080); unlock_w();
    wr(20'h00555, 16'h0010); idle(1);
    unlock_w(); wr(20'h00555, 16'h0080); unlock_w(); wr(20'h23456, 16'h0030); idle(1);
    unlock_w(); wr(20'h00555, 16'h0080); unlock_w(); wr(20'h00556, 16'h0010); idle(1);
    unlock_w(); wr(20'h00555, 16'h0080); wr(20'h00555, 16'h0055); idle(2);

    cur_req = "R11";
    unlock_w(); wr(20'h00555, 16'h0080); unlock_w(); wr(20'h45678, 16'h0030);
    busy = 1'b1; unlock_w(); wr(20'h00555, 16'h0090); wr(20'h00000, 16'h00F0);
    wr(20'h00000, 16'h00B0); wr(20'h00000, 16'h00B0);
    busy = 1'b0; wr(20'h00000, 16'h0011);
    busy = 1'b1; wr(20'h00000, 16'h00B0);
    busy = 1'b0; unlock_w(); wr(20'h00555, 16'h00A0); wr(20'h00010, 16'h0042);
    busy = 1'b1; wr(20'h00000, 16'h00B0); busy = 1'b0; idle(2);

    cur_req = "R1"; @(negedge clk) rst = 1'b1; idle(2); @(negedge clk) rst = 1'b0; idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule